// File: doc/BRIEF.md
# SPI Master with Packet Counter

This block is one channel of a register-driven SPI master. Software configures it, pushes transmit units into a TX FIFO and pops received units from an RX FIFO, all through a small register port with address, write, read and data lines. Each unit is either 8 bits (byte mode) or 32 bits (word mode). It is shifted MSB first in SPI mode 0: SCLK idles low, MOSI changes on the falling edge, and MISO is sampled on the rising edge. SCLK runs at a fixed division of the system clock.

A packet counter lets the master clock a set number of units on its own. While the count is enabled and the TX FIFO runs dry, the master sends all-ones filler so that a reply can be collected. In word mode, independent byte and halfword swap controls for each direction convert between bus order and memory order. A soft reset empties both FIFOs and clears the status flags, and it leaves the configuration untouched. Chip select is a plain register bit.

Top module: `spi_pkt_master`

## Requirements
- R1: After reset, cs_n is 1, sclk is 0, both FIFO levels are 0, the TX-done flag is 1, both error flags are 0, and every configuration register reads 0 except the select register, which reads 1.
- R2: The register addresses are as follows. 0 is control: bit0 TX channel on, bit1 RX channel on, bit2 soft reset, bit3 word mode. 1 is swap. 2 is packet count. 3 is select. A write to 4 pushes TX. A read of 5 pops RX. 6 is status. Registers 0 to 3 read back the value last written.
- R3: cs_n follows bit0 of the select register. Writing 1 makes the select inactive and writing 0 makes it active.
- R4: Mode 0 timing: sclk is low whenever the master is idle. MOSI carries the unit MSB first and holds steady across every rising edge. MISO is sampled on rising edges. One unit produces exactly as many rising edges as it has bits.
- R5: In byte mode a unit is the low 8 bits of a TX entry. The received unit is stored zero-extended to 32 bits.
- R6: In word mode a unit is 32 bits. Swap bits are: bit0 TX enable, bit1 TX byte swap (bytes within each halfword), bit2 TX halfword swap, and bits 3, 4 and 5 the same for the received word. A swap takes effect only when its direction's enable is set and the block is in word mode.
- R7: Packet-count bits [15:0] give a unit count and bit16 enables it. While it is enabled, exactly that many units are clocked and then clocking stops, even if TX data remains. TX entries are used while present and all-ones filler is sent otherwise.
- R8: With the packet count disabled, units are clocked only while the TX FIFO holds data.
- R9: Each FIFO holds DEPTH entries. Status bits [7:0] give the TX level and bits [15:8] the RX level.
- R10: Status bit16 (TX done) is 1 exactly when the TX FIFO is empty, the shifter is idle and no counted units are pending.
- R11: A push into a full TX FIFO or a pop from an empty RX FIFO changes no FIFO. The push sets sticky status bit17 and the pop sets sticky status bit18.
- R12: While the soft reset bit is 1, both FIFOs are emptied, both error flags are cleared and any unit in flight is aborted. The control, swap, packet-count and select registers keep their values.
- R13: With the TX channel off no unit starts. With the RX channel off, received units are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 3 | Register address |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rd | input | 1 | Register read strobe (pops RX at address 5) |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 1 | Active-low chip select |

## Verification
The bench builds the block with DEPTH=4 and DIV=2. The small FIFO lets a handful of pushes reach the overflow flag and the full-level boundary. The short clock division keeps a 32-bit unit at 128 system cycles, so every swap combination can be exercised in word mode within a short run. MISO is looped back from MOSI for the swap table and driven as a constant otherwise, which separates the transmit-side swap from the receive-side swap.

// File: rtl/spi_pkt_master.sv
module spi_pkt_master #(
  parameter int DEPTH = 64,
  parameter int DIV   = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [2:0]  reg_addr,
  input  logic        reg_wr,
  input  logic [31:0] reg_wdata,
  input  logic        reg_rd,
  output logic [31:0] reg_rdata,
  output logic        sclk,
  output logic        mosi,
  input  logic        miso,
  output logic        cs_n
);
  localparam int AW  = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int LW  = $clog2(DEPTH + 1);
  localparam int DCW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [LW-1:0] FULL = LW'(DEPTH);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic tx_on_q, rx_on_q, srst_q, wmode_q, cs_q, pkt_en_q;
  logic [5:0]  swap_q;
  logic [15:0] pkt_q, rem_q;
  logic        tx_ovf_q, rx_unf_q;

  logic [31:0]   tx_mem [DEPTH];
  logic [31:0]   rx_mem [DEPTH];
  logic [AW-1:0] tx_wp, tx_rp, rx_wp, rx_rp;
  logic [LW-1:0] tx_lvl, rx_lvl;

  logic          busy_q;
  logic [DCW-1:0] dcnt;
  logic [4:0]    bitcnt;
  logic [31:0]   tx_sh, rx_sh;

  function automatic logic [31:0] swp(input logic [31:0] d, input logic en,
                                      input logic bs, input logic hs);
    logic [31:0] t;
    t = d;
    if (en && bs) t = {t[23:16], t[31:24], t[7:0], t[15:8]};
    if (en && hs) t = {t[15:0], t[31:16]};
    return t;
  endfunction

  wire wr_tx   = reg_wr && reg_addr == 3'd4;
  wire rd_rx   = reg_rd && reg_addr == 3'd5;
  wire push_ok = wr_tx && tx_lvl != FULL && !srst_q;
  wire pop_ok  = rd_rx && rx_lvl != '0 && !srst_q;
  wire tx_has  = tx_lvl != '0;
  wire start   = !busy_q && !srst_q && tx_on_q && (pkt_en_q ? rem_q != '0 : tx_has);
  wire tx_pop  = start && tx_has;
  wire tick    = dcnt == DCW'(DIV - 1);
  wire [4:0] last_bit = wmode_q ? 5'd31 : 5'd7;
  wire unit_end = busy_q && tick && sclk && bitcnt == last_bit;
  wire rx_push = unit_end && rx_on_q && rx_lvl != FULL;

  wire [31:0] tx_src  = tx_has ? tx_mem[tx_rp] : '1;
  wire [31:0] tx_load = wmode_q ? swp(tx_src, swap_q[0], swap_q[1], swap_q[2])
                                : {tx_src[7:0], 24'h0};
  wire [31:0] rx_word = wmode_q ? swp(rx_sh, swap_q[3], swap_q[4], swap_q[5])
                                : {24'h0, rx_sh[7:0]};
  wire tx_done = !busy_q && !tx_has && !(tx_on_q && pkt_en_q && rem_q != '0);
  wire [31:0] status_w = {13'h0, rx_unf_q, tx_ovf_q, tx_done, 8'(rx_lvl), 8'(tx_lvl)};

  assign mosi  = tx_sh[31];
  assign cs_n  = cs_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {tx_on_q, rx_on_q, srst_q, wmode_q} <= '0;
      swap_q <= '0; pkt_q <= '0; pkt_en_q <= 1'b0; cs_q <= 1'b1; rem_q <= '0;
    end else begin
      if (reg_wr) begin
        case (reg_addr)
          3'd0: {wmode_q, srst_q, rx_on_q, tx_on_q} <= reg_wdata[3:0];
          3'd1: swap_q <= reg_wdata[5:0];
          3'd2: {pkt_en_q, pkt_q} <= reg_wdata[16:0];
          3'd3: cs_q <= reg_wdata[0];
          default: ;
        endcase
      end
      if (reg_wr && reg_addr == 3'd2) rem_q <= reg_wdata[15:0];
      else if (start && pkt_en_q) rem_q <= rem_q - 16'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_ovf_q <= 1'b0; rx_unf_q <= 1'b0;
    end else if (srst_q) begin
      tx_ovf_q <= 1'b0; rx_unf_q <= 1'b0;
    end else begin
      if (wr_tx && tx_lvl == FULL) tx_ovf_q <= 1'b1;
      if (rd_rx && rx_lvl == '0)   rx_unf_q <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) tx_mem[tx_wp] <= reg_wdata;
    if (rx_push) rx_mem[rx_wp] <= rx_word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n || srst_q) begin
      tx_wp <= '0; tx_rp <= '0; tx_lvl <= '0;
      rx_wp <= '0; rx_rp <= '0; rx_lvl <= '0;
    end else begin
      if (push_ok) tx_wp <= (tx_wp == LAST) ? '0 : tx_wp + 1'b1;
      if (tx_pop)  tx_rp <= (tx_rp == LAST) ? '0 : tx_rp + 1'b1;
      if (push_ok && !tx_pop) tx_lvl <= tx_lvl + 1'b1;
      else if (!push_ok && tx_pop) tx_lvl <= tx_lvl - 1'b1;
      if (rx_push) rx_wp <= (rx_wp == LAST) ? '0 : rx_wp + 1'b1;
      if (pop_ok)  rx_rp <= (rx_rp == LAST) ? '0 : rx_rp + 1'b1;
      if (rx_push && !pop_ok) rx_lvl <= rx_lvl + 1'b1;
      else if (!rx_push && pop_ok) rx_lvl <= rx_lvl - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0; sclk <= 1'b0; dcnt <= '0; bitcnt <= '0;
      tx_sh <= '0; rx_sh <= '0;
    end else if (srst_q) begin
      busy_q <= 1'b0; sclk <= 1'b0; dcnt <= '0; bitcnt <= '0;
    end else if (start) begin
      busy_q <= 1'b1; sclk <= 1'b0; dcnt <= '0; bitcnt <= '0;
      tx_sh <= tx_load;
    end else if (busy_q) begin
      if (tick) begin
        dcnt <= '0;
        sclk <= ~sclk;
        if (!sclk) rx_sh <= {rx_sh[30:0], miso};
        else begin
          tx_sh <= {tx_sh[30:0], 1'b0};
          if (bitcnt == last_bit) busy_q <= 1'b0;
          else bitcnt <= bitcnt + 5'd1;
        end
      end else dcnt <= dcnt + 1'b1;
    end
  end

  always_comb begin
    case (reg_addr)
      3'd0: reg_rdata = {28'h0, wmode_q, srst_q, rx_on_q, tx_on_q};
      3'd1: reg_rdata = {26'h0, swap_q};
      3'd2: reg_rdata = {15'h0, pkt_en_q, pkt_q};
      3'd3: reg_rdata = {31'h0, cs_q};
      3'd5: reg_rdata = (rx_lvl != '0) ? rx_mem[rx_rp] : 32'h0;
      3'd6: reg_rdata = status_w;
      default: reg_rdata = 32'h0;
    endcase
  end
endmodule

module spi_pkt_master_chk #(
  parameter int DEPTH = 64
) (
  input logic        clk,
  input logic        rst_n,
  input logic        sclk,
  input logic        mosi,
  input logic        cs_n,
  input logic [2:0]  reg_addr,
  input logic        reg_wr,
  input logic [31:0] reg_wdata,
  input logic [31:0] status,
  input logic        srst
);
  // R4
  idle_clock_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    status[16] |-> !sclk);
  // R4
  mosi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sclk) |-> $stable(mosi));
  // R3
  cs_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 3'd3) |=> cs_n == $past(reg_wdata[0]));
  // R9
  level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status[7:0] <= 8'(DEPTH)) && (status[15:8] <= 8'(DEPTH)));
  // R11
  overflow_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 3'd4 && status[7:0] == 8'(DEPTH) && !srst) |=> status[17]);
  // R12
  soft_reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    srst |=> (status[15:0] == 16'h0 && !status[17] && !status[18]));
  // R10
  done_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    status[16] |-> status[7:0] == 8'h0);
endmodule

bind spi_pkt_master spi_pkt_master_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .sclk(sclk), .mosi(mosi), .cs_n(cs_n),
  .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
  .status(status_w), .srst(srst_q)
);

// File: tb/tb_spi_pkt_master.sv
module tb_spi_pkt_master;
  localparam int DEPTH = 4;
  localparam int DIV   = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [2:0] reg_addr = '0;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic sclk, mosi, cs_n, miso;
  logic lb = 1'b1, miso_k = 1'b0;
  int total = 0, bad = 0, rises = 0;

  assign miso = lb ? mosi : miso_k;
  always #10 clk = ~clk;
  always @(posedge sclk) rises++;

  spi_pkt_master #(.DEPTH(DEPTH), .DIV(DIV)) dut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rd(reg_rd), .reg_rdata(reg_rdata),
    .sclk(sclk), .mosi(mosi), .miso(miso), .cs_n(cs_n));

  // {word mode, swap[5:0], tx data, expected rx}
  localparam logic [70:0] VEC [10] = '{
    {1'b0, 6'h00, 32'h000000A5, 32'h000000A5},
    {1'b0, 6'h3F, 32'h12345678, 32'h00000078},
    {1'b1, 6'h00, 32'h12345678, 32'h12345678},
    {1'b1, 6'h03, 32'h12345678, 32'h34127856},
    {1'b1, 6'h05, 32'h12345678, 32'h56781234},
    {1'b1, 6'h07, 32'h12345678, 32'h78563412},
    {1'b1, 6'h18, 32'h12345678, 32'h34127856},
    {1'b1, 6'h1B, 32'h12345678, 32'h12345678},
    {1'b1, 6'h02, 32'h12345678, 32'h12345678},
    {1'b1, 6'h3D, 32'h12345678, 32'h34127856}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_rd = 1'b1;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic wait_done();
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      reg_addr = 3'd6;
      #1;
      if (reg_rdata[16]) break;
    end
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog R10 act=timeout exp=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd(3'd6, d); chk("R1 status", d, 32'h0001_0000);
    chk("R1 cs_n", {31'h0, cs_n}, 32'h1);
    chk("R1 sclk", {31'h0, sclk}, 32'h0);
    rd(3'd0, d); chk("R1 ctrl", d, 32'h0);
    // R2 readback
    wr(3'd1, 32'h2A); rd(3'd1, d); chk("R2 swap", d, 32'h2A);
    wr(3'd2, 32'h1_0005); rd(3'd2, d); chk("R2 pkt", d, 32'h1_0005);
    wr(3'd2, 32'h0); wr(3'd1, 32'h0);
    // R3 select
    wr(3'd3, 32'h0); chk("R3 active", {31'h0, cs_n}, 32'h0);
    wr(3'd3, 32'h1); chk("R3 inactive", {31'h0, cs_n}, 32'h1);
    // R5 / R6 vector table with loopback
    for (int i = 0; i < 10; i++) begin
      wr(3'd0, {28'h0, VEC[i][70], 3'b011});
      wr(3'd1, {26'h0, VEC[i][69:64]});
      wr(3'd4, VEC[i][63:32]);
      wait_done();
      rd(3'd5, d);
      chk(VEC[i][70] ? "R6 word swap" : "R5 byte unit", d, VEC[i][31:0]);
    end
    wr(3'd1, 32'h0);
    // R4 edge count per byte unit
    wr(3'd0, 32'h3); rises = 0;
    wr(3'd4, 32'hA5); wait_done();
    chk("R4 rising edges", rises, 32'd8);
    rd(3'd5, d);
    // R7 filler with packet count
    rises = 0;
    wr(3'd2, 32'h1_0003); wait_done();
    rd(3'd6, d); chk("R7 rx level", d, 32'h0001_0300);
    chk("R7 edges", rises, 32'd24);
    for (int i = 0; i < 3; i++) begin
      rd(3'd5, d); chk("R7 filler", d, 32'hFF);
    end
    // R7 count stops with data left, R8 count off drains
    wr(3'd0, 32'h0); wr(3'd2, 32'h0);
    wr(3'd4, 32'h11); wr(3'd4, 32'h22);
    wr(3'd2, 32'h1_0001); wr(3'd0, 32'h3);
    repeat (200) @(negedge clk);
    rd(3'd6, d); chk("R7 stop", d, 32'h0000_0101);
    rd(3'd5, d); chk("R7 data", d, 32'h11);
    wr(3'd2, 32'h0); wait_done();
    rd(3'd5, d); chk("R8 drain", d, 32'h22);
    // R11 overflow and underflow
    wr(3'd0, 32'h0);
    for (int i = 0; i < DEPTH + 1; i++) wr(3'd4, 32'h40 + i);
    rd(3'd6, d); chk("R11 overflow", d, 32'h0002_0004);
    rd(3'd5, d);
    rd(3'd6, d); chk("R11 underflow", d, 32'h0006_0004);
    // R12 soft reset keeps configuration
    wr(3'd1, 32'h15); wr(3'd2, 32'h7); wr(3'd3, 32'h0);
    wr(3'd0, 32'hC); wr(3'd0, 32'h8);
    rd(3'd6, d); chk("R12 status", d, 32'h0001_0000);
    rd(3'd1, d); chk("R12 swap kept", d, 32'h15);
    rd(3'd2, d); chk("R12 pkt kept", d, 32'h7);
    rd(3'd0, d); chk("R12 ctrl kept", d, 32'h8);
    chk("R12 cs kept", {31'h0, cs_n}, 32'h0);
    wr(3'd2, 32'h0); wr(3'd1, 32'h0); wr(3'd3, 32'h1);
    // R13 RX off discards, TX off holds
    wr(3'd0, 32'h1); wr(3'd4, 32'h5A); wait_done();
    rd(3'd6, d); chk("R13 rx off", d, 32'h0001_0000);
    rises = 0;
    wr(3'd0, 32'h2); wr(3'd4, 32'h5A);
    repeat (100) @(negedge clk);
    rd(3'd6, d); chk("R13 tx off", d, 32'h0000_0001);
    chk("R13 no clock", rises, 32'd0);
    wr(3'd0, 32'h4); wr(3'd0, 32'h0);
    // R4 MISO sampled independently of MOSI
    lb = 1'b0; miso_k = 1'b0;
    wr(3'd0, 32'h3); wr(3'd4, 32'hFF); wait_done();
    rd(3'd5, d); chk("R4 miso low", d, 32'h00);
    miso_k = 1'b1;
    wr(3'd4, 32'h00); wait_done();
    rd(3'd5, d); chk("R4 miso high", d, 32'hFF);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule